// File: doc/BRIEF.md
# Bipolar Charge-Pulse Integrator DAC

This block turns a simple tri-stateable digital pin into the drive of a slow, high-resolution DAC built around an external analog integrator. Once per frame, at a fixed repetition rate, it drives the pin high for a programmed time, then low for a programmed time, and then releases it to high impedance. When both times are equal, the integrator receives no net charge. A longer high phase steps the integrator one way and a longer low phase steps it the other way. All of the injected ripple therefore sits at the frame rate, where it is easy to filter.

A controller supplies a signed fixed-point correction word. Its integer part sets how unbalanced the pulse pair is in clock ticks. Its fractional part feeds a first-order accumulator, and the accumulator's carry adds one tick to the imbalance on a matching fraction of frames. This lets small, steady corrections, such as cancelling leakage or offset, average out across frames. Each phase width is clamped so that the pair always fits inside the frame, and a saturation flag reports when the clamp acts.

A startup select output switches in the fast-charge input path of the integrator. The correction, enable and startup inputs are read only at the frame boundary, which is marked by a one-clock strobe. The controller can use that strobe to pace its ADC reads and updates.

Top module: `bipulse_dac`

## Requirements
- R1: `frame_strobe_o` is high for exactly one clock every `FRAME_CYC` clocks. `enable_i`, `startup_i` and `corr_i` are sampled only in the clock where the strobe is high, and they govern the frame that starts on the next clock.
- R2: The frame begins at index 0, which is the strobe clock. In an enabled frame, index 1 has data=1 and oe=0. Indices 2 to 1+T_high have data=1 and oe=1. The next T_low indices have data=0 and oe=1. All later indices, and index 0, have data=0 and oe=0. The rising edge of oe is always preceded by data=1, and the pin is released while data is 0.
- R3: `corr_i` is two's complement with `FRAC_W` fraction bits. The imbalance is e = floor(corr/2^FRAC_W) + carry. If e >= 0, then T_high = `BASE_HALF` + e and T_low = `BASE_HALF`. If e < 0, then T_high = `BASE_HALF` and T_low = `BASE_HALF` - e.
- R4: Each enabled frame adds the low `FRAC_W` bits of `corr_i` into a `FRAC_W`-bit accumulator, and the carry out of that sum is the carry in R3. Over 2^FRAC_W enabled frames that start from a cleared accumulator, with a constant unclamped input, the sum of (T_high - T_low) equals `corr_i` read as an integer.
- R5: |e| is clamped to MAXE = `FRAME_CYC` - 2 - 2*`BASE_HALF`. `sat_o` is 1 during a frame whose imbalance was clamped and 0 otherwise.
- R6: Changes to `enable_i`, `startup_i` or `corr_i` outside the strobe clock do not alter the pin waveform, `sat_o` or `fast_sel_o` of the frame in progress.
- R7: A frame that sampled `enable_i`=0 keeps oe=0 and data=0 throughout, has `sat_o`=0, and clears the dither accumulator.
- R8: `fast_sel_o` equals the `startup_i` value sampled at the last boundary, whether or not that frame is enabled.
- R9: While reset is active, and until the first frame starts, oe, data, `sat_o`, `fast_sel_o` and `frame_strobe_o` are 0. The first strobe comes on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Allows pulse pairs, sampled at the boundary |
| startup_i | input | 1 | Startup request, sampled at the boundary |
| corr_i | input | INT_W+FRAC_W | Signed fixed-point correction |
| pin_data_o | output | 1 | Value to drive on the pin |
| pin_oe_o | output | 1 | Pin driver enable, 1 = driven |
| fast_sel_o | output | 1 | Selects the fast-charge integrator input path |
| sat_o | output | 1 | Imbalance was clamped in this frame |
| frame_strobe_o | output | 1 | One-clock frame boundary marker |

## Verification
A corrupted frame counter moves the strobe or the oe window, and this is visible within one frame. A wrong width register shows up as a high or low count that differs from the arithmetic expectation in the very frame it governs. Dither accumulator faults can hide in a single frame, but they appear as a wrong sum over the 2^FRAC_W frames of a sweep point. A stale accumulator after a disabled frame shows up in the first enabled frame that follows. Every correction value is swept, with the inputs changed in the middle of each frame to expose any sampling that is not confined to the boundary.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_HIGH  = 2'd2,
        PH_LOW   = 2'd3
    } phase_e;
endpackage

// File: rtl/bpd_frame_counter.sv
module bpd_frame_counter #(
    parameter int FRAME_CYC = 12500,
    parameter int CW        = 14
) (
    input  logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nxt
);
    localparam logic [CW-1:0] LAST = CW'(FRAME_CYC - 1);

    always_comb begin
        if (cnt_q == LAST) cnt_nxt = '0;
        else               cnt_nxt = cnt_q + 1'b1;
    end
endmodule

// File: rtl/bpd_dither.sv
module bpd_dither #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 8
) (
    input  logic [INT_W+FRAC_W-1:0] corr,
    input  logic [FRAC_W-1:0]       acc_q,
    output logic signed [INT_W:0]   imb,
    output logic [FRAC_W-1:0]       acc_nxt
);
    logic [INT_W-1:0]  int_part;
    logic [FRAC_W-1:0] frac_part;
    logic [FRAC_W:0]   sum;

    always_comb begin
        int_part  = corr[INT_W+FRAC_W-1:FRAC_W];
        frac_part = corr[FRAC_W-1:0];
        sum       = {1'b0, acc_q} + {1'b0, frac_part};
        acc_nxt   = sum[FRAC_W-1:0];
        imb       = $signed({int_part[INT_W-1], int_part})
                  + $signed({{INT_W{1'b0}}, sum[FRAC_W]});
    end
endmodule

// File: rtl/bpd_width_calc.sv
module bpd_width_calc #(
    parameter int CW        = 14,
    parameter int IW        = 9,
    parameter int BASE_HALF = 4000,
    parameter int MAXE      = 4498
) (
    input  logic signed [IW-1:0] imb,
    output logic [CW-1:0]        t_high,
    output logic [CW-1:0]        t_low,
    output logic                 clamped
);
    localparam int MW = ((CW > IW) ? CW : IW) + 1;
    localparam logic [MW-1:0] MAXE_EXT = MW'(MAXE);
    localparam logic [CW-1:0] BASE     = CW'(BASE_HALF);

    logic          neg;
    logic [IW-1:0] mag;
    logic [MW-1:0] mag_ext;
    logic [MW-1:0] lim;
    logic [CW-1:0] ext;

    always_comb begin
        neg     = imb[IW-1];
        mag     = neg ? (~imb + 1'b1) : imb;
        mag_ext = {{(MW-IW){1'b0}}, mag};
        clamped = (mag_ext > MAXE_EXT);
        lim     = clamped ? MAXE_EXT : mag_ext;
        ext     = lim[CW-1:0];
        t_high  = neg ? BASE : BASE + ext;
        t_low   = neg ? BASE + ext : BASE;
    end
endmodule

// File: rtl/bpd_phase_decode.sv
module bpd_phase_decode
    import bpd_pkg::*;
#(
    parameter int CW = 14
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] t_high,
    input  logic [CW-1:0] t_low,
    input  logic          live,
    output phase_e        phase
);
    logic [CW-1:0] hi_end;
    logic [CW-1:0] lo_end;

    always_comb begin
        hi_end = CW'(2) + t_high;
        lo_end = hi_end + t_low;
        if (!live)                                  phase = PH_IDLE;
        else if (cnt == CW'(1))                     phase = PH_SETUP;
        else if (cnt >= CW'(2) && cnt < hi_end)     phase = PH_HIGH;
        else if (cnt >= hi_end && cnt < lo_end)     phase = PH_LOW;
        else                                        phase = PH_IDLE;
    end
endmodule

// File: rtl/bipulse_dac.sv
module bipulse_dac
    import bpd_pkg::*;
#(
    parameter int FRAME_CYC = 12500,
    parameter int BASE_HALF = 4000,
    parameter int INT_W     = 8,
    parameter int FRAC_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable_i,
    input  logic                    startup_i,
    input  logic [INT_W+FRAC_W-1:0] corr_i,
    output logic                    pin_data_o,
    output logic                    pin_oe_o,
    output logic                    fast_sel_o,
    output logic                    sat_o,
    output logic                    frame_strobe_o
);
    localparam int CW   = $clog2(FRAME_CYC + 1);
    localparam int IW   = INT_W + 1;
    localparam int MAXE = FRAME_CYC - 2 - 2 * BASE_HALF;

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [CW-1:0]     th;
        logic [CW-1:0]     tl;
        logic [FRAC_W-1:0] acc;
        logic              live;
        logic              fast;
        logic              sat;
        logic              strobe;
        logic              data;
        logic              oe;
    } state_t;

    state_t st_q, st_d;

    logic [CW-1:0]        cnt_nxt;
    logic signed [IW-1:0] imb;
    logic [FRAC_W-1:0]    acc_nxt;
    logic [CW-1:0]        calc_th, calc_tl;
    logic                 calc_sat;
    logic                 boundary;
    logic [CW-1:0]        th_nxt, tl_nxt;
    logic                 live_nxt;
    phase_e               phase_nxt;

    bpd_frame_counter #(.FRAME_CYC(FRAME_CYC), .CW(CW)) u_counter (
        .cnt_q   (st_q.cnt),
        .cnt_nxt (cnt_nxt)
    );

    bpd_dither #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_dither (
        .corr    (corr_i),
        .acc_q   (st_q.acc),
        .imb     (imb),
        .acc_nxt (acc_nxt)
    );

    bpd_width_calc #(.CW(CW), .IW(IW), .BASE_HALF(BASE_HALF), .MAXE(MAXE)) u_width (
        .imb     (imb),
        .t_high  (calc_th),
        .t_low   (calc_tl),
        .clamped (calc_sat)
    );

    // Boundary-sampled frame parameters, seen by the decoder one cycle ahead.
    assign boundary = (st_q.cnt == '0);
    assign live_nxt = boundary ? enable_i : st_q.live;
    assign th_nxt   = boundary ? (enable_i ? calc_th : '0) : st_q.th;
    assign tl_nxt   = boundary ? (enable_i ? calc_tl : '0) : st_q.tl;

    bpd_phase_decode #(.CW(CW)) u_decode (
        .cnt    (cnt_nxt),
        .t_high (th_nxt),
        .t_low  (tl_nxt),
        .live   (live_nxt),
        .phase  (phase_nxt)
    );

    always_comb begin
        st_d        = st_q;
        st_d.cnt    = cnt_nxt;
        st_d.th     = th_nxt;
        st_d.tl     = tl_nxt;
        st_d.live   = live_nxt;
        if (boundary) begin
            st_d.fast = startup_i;
            st_d.sat  = enable_i & calc_sat;
            st_d.acc  = enable_i ? acc_nxt : '0;
        end
        st_d.strobe = (cnt_nxt == '0);
        st_d.data   = (phase_nxt == PH_SETUP) || (phase_nxt == PH_HIGH);
        st_d.oe     = (phase_nxt == PH_HIGH) || (phase_nxt == PH_LOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= CW'(FRAME_CYC - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_data_o     = st_q.data;
    assign pin_oe_o       = st_q.oe;
    assign fast_sel_o     = st_q.fast;
    assign sat_o          = st_q.sat;
    assign frame_strobe_o = st_q.strobe;
endmodule

// File: rtl/bpd_checker.sv
module bpd_checker #(
    parameter int FRAME_CYC = 12500
) (
    input logic clk,
    input logic rst_n,
    input logic pin_data_o,
    input logic pin_oe_o,
    input logic fast_sel_o,
    input logic sat_o,
    input logic frame_strobe_o
);
    logic [31:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (frame_strobe_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    p_frame_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe_o && seen_q) |-> (gap_q == 32'(FRAME_CYC - 1)));

    p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe_o |=> !frame_strobe_o);

    p_data_leads_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_oe_o) |-> ($past(pin_data_o) && pin_data_o));

    p_release_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_oe_o) |-> !$past(pin_data_o));

    p_hiz_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe_o |-> !pin_oe_o);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe_o |=> ($stable(fast_sel_o) && $stable(sat_o)));
endmodule

bind bipulse_dac bpd_checker #(.FRAME_CYC(FRAME_CYC)) u_bpd_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .pin_data_o     (pin_data_o),
    .pin_oe_o       (pin_oe_o),
    .fast_sel_o     (fast_sel_o),
    .sat_o          (sat_o),
    .frame_strobe_o (frame_strobe_o)
);

// File: tb/test_bipulse_dac.sv
module test_bipulse_dac;
    localparam int F    = 32;
    localparam int BH   = 8;
    localparam int IW   = 5;
    localparam int FW   = 3;
    localparam int MAXE = F - 2 - 2 * BH;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic       st_i = 1'b0;
    logic [7:0] corr_i = '0;
    logic       pin_data_o, pin_oe_o, fast_sel_o, sat_o, frame_strobe_o;

    int n_tests = 0;
    int n_fail  = 0;
    int acc_m   = 0;

    always #4 clk = ~clk;

    bipulse_dac #(.FRAME_CYC(F), .BASE_HALF(BH), .INT_W(IW), .FRAC_W(FW)) i_bipulse_dac (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable_i       (en_i),
        .startup_i      (st_i),
        .corr_i         (corr_i),
        .pin_data_o     (pin_data_o),
        .pin_oe_o       (pin_oe_o),
        .fast_sel_o     (fast_sel_o),
        .sat_o          (sat_o),
        .frame_strobe_o (frame_strobe_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    // Starts at the negedge of a strobe cycle and ends at the next one.
    task automatic run_frame(input bit en, input int c, input bit st, output int diff, output bit sat_e);
        int s, car, ip, e, mag, th, tl, hi, lo, err_pre, err_post, err_fast, err_sat, err_stb;
        corr_i = c[7:0];
        en_i   = en;
        st_i   = st;
        sat_e  = 1'b0;
        th = 0; tl = 0;
        if (en) begin
            s     = acc_m + (c & 7);
            car   = s >> 3;
            acc_m = s & 7;
            ip    = c >>> 3;
            e     = ip + car;
            mag   = (e < 0) ? -e : e;
            if (mag > MAXE) begin
                mag   = MAXE;
                sat_e = 1'b1;
            end
            th = (e < 0) ? BH : BH + mag;
            tl = (e < 0) ? BH + mag : BH;
        end else begin
            acc_m = 0;
        end
        hi = 0; lo = 0; err_pre = 0; err_post = 0; err_fast = 0; err_sat = 0; err_stb = 0;
        for (int k = 1; k < F; k++) begin
            bit exp_oe, exp_d;
            @(negedge clk);
            exp_oe = en && (k >= 2) && (k < 2 + th + tl);
            exp_d  = en && ((k == 1) || ((k >= 2) && (k < 2 + th)));
            if (pin_oe_o !== exp_oe || pin_data_o !== exp_d) begin
                if (k <= 5) err_pre++;
                else        err_post++;
            end
            if (pin_oe_o === 1'b1 && pin_data_o === 1'b1) hi++;
            if (pin_oe_o === 1'b1 && pin_data_o === 1'b0) lo++;
            if (fast_sel_o !== st) err_fast++;
            if (sat_o !== sat_e) err_sat++;
            if (frame_strobe_o !== 1'b0) err_stb++;
            if (k == 5) begin
                corr_i = ~c[7:0];
                en_i   = !en;
                st_i   = !st;
            end
        end
        @(negedge clk);
        check(frame_strobe_o === 1'b1 && err_stb == 0, "R1 strobe period", err_stb, 0);
        check(pin_oe_o === 1'b0, "R2 released at boundary", int'(pin_oe_o), 0);
        if (en) begin
            check(err_pre == 0, "R2 pulse shape", err_pre, 0);
            check(hi == th, "R3 high width", hi, th);
            check(lo == tl, "R3 low width", lo, tl);
            check(err_sat == 0, "R5 saturation flag", err_sat, 0);
        end else begin
            check(err_pre == 0 && hi == 0 && lo == 0, "R7 no pulse while disabled", hi + lo + err_pre, 0);
            check(err_sat == 0, "R7 sat low while disabled", err_sat, 0);
        end
        check(err_post == 0, "R6 mid-frame input change", err_post, 0);
        check(err_fast == 0, "R8 fast select", err_fast, 0);
        diff = hi - lo;
    endtask

    initial begin
        int  d;
        bit  sf;
        repeat (3) @(negedge clk);
        check(pin_oe_o === 1'b0 && pin_data_o === 1'b0, "R9 pin idle in reset",
              int'(pin_oe_o) + int'(pin_data_o), 0);
        check(sat_o === 1'b0 && fast_sel_o === 1'b0 && frame_strobe_o === 1'b0,
              "R9 flags low in reset", int'(sat_o) + int'(fast_sel_o) + int'(frame_strobe_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(frame_strobe_o === 1'b1, "R9 first strobe after reset", int'(frame_strobe_o), 1);

        // R7: nothing driven until enable is sampled high
        for (int i = 0; i < 3; i++) run_frame(1'b0, 50, 1'b1, d, sf);

        // Full sweep: cleared accumulator, then 2^FRAC_W frames per value (R3, R4, R5)
        for (int c = -128; c < 128; c++) begin
            int  sum;
            bit  any_sat;
            run_frame(1'b0, c, c[0], d, sf);
            sum = 0;
            any_sat = 1'b0;
            for (int f = 0; f < 8; f++) begin
                run_frame(1'b1, c, c[1], d, sf);
                sum += d;
                any_sat |= sf;
            end
            if (!any_sat) check(sum == c, "R4 dither average", sum, c);
        end

        summary();
        $finish;
    end
endmodule